// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This unit sits between a 32-bit load/store pipeline and a byte-addressed data memory that stores words in big-endian order: the byte at offset 0 of a word lives in bits 31:24. For each request it forms the effective address from a base register and a signed 16-bit displacement. It drives the word-aligned address and a per-lane byte-enable mask. For stores it places the register data on the lanes being written. When the memory word comes back on a load, it pulls out the addressed byte or halfword and widens it with sign or zero fill. An upper-immediate request uses the same result port without touching memory.

Requests are taken every cycle and registered once. The memory strobes, address, mask and write data appear one cycle after the request. During that cycle the memory returns its word, and the load result is formed from it combinationally. A misaligned or illegal-size access raises an error flag in place of any memory strobe. The lanes that a halfword or byte store does not cover get a zero enable bit, so the memory keeps those bytes unchanged.

Top module: `lsu_lane_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mem_we`, `mem_re`, `align_err` and `ld_valid` are 0, and `mem_be` and `ld_data` are all zeros.
- R2: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits. One cycle after a load or store request, `mem_addr` equals that address with bits 1:0 cleared.
- R3: Request size is encoded in `req_size` as 00 byte, 01 halfword, 10 word, 11 reserved. A halfword with address bit 0 set, a word with either of address bits 1:0 set, or a reserved size makes a load or store misaligned. One cycle later `align_err` is 1 and `mem_be`, `mem_we`, `mem_re` and `ld_valid` are all 0.
- R4: For an aligned load or store, `mem_be` bit 3-k enables the byte at offset k (offset = address bits 1:0). A byte access enables one bit. A halfword enables 1100 at offset 0 and 0011 at offset 2. A word enables 1111.
- R5: Store data is replicated across lanes. A byte store drives bits 7:0 of `req_wdata` onto all four lanes. A halfword store drives bits 15:0 onto both halves. A word store drives `req_wdata` unchanged.
- R6: Requests are encoded in `req_kind` as 00 idle, 01 load, 10 store, 11 upper immediate. An aligned store asserts only `mem_we` and an aligned load asserts only `mem_re`, one cycle after the request.
- R7: A load extracts the data in big-endian order. The byte at offset k comes from `mem_rdata` bits 31-8k down to 24-8k. The halfword at offset 0 comes from bits 31:16 and the one at offset 2 from bits 15:0. A word load returns all of `mem_rdata`. `ld_valid` is 1 for aligned loads.
- R8: When `req_unsigned` is 0, byte and halfword loads fill the upper bits with bit 7 or bit 15 of the extracted field. When it is 1, they fill with zeros. It has no effect on word loads.
- R9: An upper-immediate request returns `ld_data` = {`req_disp`, 16'h0000} with `ld_valid` 1 one cycle later, ignores `mem_rdata`, and asserts none of `mem_we`, `mem_re`, `align_err` or any `mem_be` bit.
- R10: An idle request leaves `mem_we`, `mem_re`, `align_err` and `ld_valid` at 0 and `mem_be` at zero in the following cycle.
- R11: Whenever `ld_valid` is 0, `ld_data` is zero, whatever `mem_rdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_kind | input | 2 | Request type: idle, load, store, upper immediate |
| req_size | input | 2 | Access size: byte, halfword, word, reserved |
| req_unsigned | input | 1 | Zero-fill select for narrow loads |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement, or immediate for upper-immediate |
| req_wdata | input | 32 | Register data for stores |
| mem_rdata | input | 32 | Memory word returned in the cycle after a load request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables, bit 3 for offset 0 |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| align_err | output | 1 | Misaligned or illegal-size access flag |
| ld_valid | output | 1 | Load or upper-immediate result valid |
| ld_data | output | 32 | Extended load or upper-immediate result |

## Verification
The only state is the single register stage holding the request type, size, sign select, byte offset and immediate. Each of these is rewritten every cycle, so a fault shows at the ports exactly one cycle after the request that loaded it, and is gone by the next request. A corrupted offset moves the enabled lane in `mem_be` and also changes which bytes of `mem_rdata` reach `ld_data`. A corrupted size or sign bit shows up as wrong fill bits or a wrong mask width. A stale type bit shows up as a strobe in the cycle after an idle or upper-immediate request. The directed cases therefore cover every offset with every size, with both fill modes, and place an idle cycle after each request.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      KIND_IDLE  = 2'b00,
      KIND_LOAD  = 2'b01,
      KIND_STORE = 2'b10,
      KIND_LUI   = 2'b11
   } lsu_kind_e;

   typedef enum logic [1:0] {
      SIZE_BYTE = 2'b00,
      SIZE_HALF = 2'b01,
      SIZE_WORD = 2'b10,
      SIZE_RSVD = 2'b11
   } lsu_size_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import lsu_lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int OFF_W  = 2
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  lsu_size_e         size_i,
   output logic [ADDR_W-1:0] word_addr_o,
   output logic [OFF_W-1:0]  offset_o,
   output logic              misalign_o
);

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] eff_addr;

   generate
      if (DISP_W < ADDR_W) begin : g_sext
         assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
      end else begin : g_full
         assign disp_ext = disp_i[ADDR_W-1:0];
      end
   endgenerate

   assign eff_addr    = base_i + disp_ext;
   assign word_addr_o = {eff_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign offset_o    = eff_addr[OFF_W-1:0];

   // R3: alignment rule per access size
   always_comb begin
      case (size_i)
         SIZE_BYTE: misalign_o = 1'b0;
         SIZE_HALF: misalign_o = offset_o[0];
         SIZE_WORD: misalign_o = |offset_o;
         default:   misalign_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_lane_pkg::*;
#(
   parameter int NLANE = 4,
   parameter int OFF_W = 2,
   localparam int DATA_W = NLANE * BYTE_W
) (
   input  lsu_size_e          size_i,
   input  logic [OFF_W-1:0]   offset_i,
   input  logic               block_i,
   input  logic [DATA_W-1:0]  data_i,
   output logic [NLANE-1:0]   be_o,
   output logic [DATA_W-1:0]  data_o
);

   // Lane i holds the byte at offset i; big-endian puts it at the top.
   generate
      for (genvar i = 0; i < NLANE; i++) begin : g_lane
         localparam logic [OFF_W-1:0] LANE = OFF_W'(i);
         localparam int WSRC = (NLANE-1-i) * BYTE_W;
         localparam int HSRC = ((i % 2) == 0) ? BYTE_W : 0;
         logic                hit;
         logic [BYTE_W-1:0]   lane_byte;

         always_comb begin
            case (size_i)
               SIZE_BYTE: hit = (offset_i == LANE);
               SIZE_HALF: hit = (offset_i[OFF_W-1:1] == LANE[OFF_W-1:1]);
               SIZE_WORD: hit = 1'b1;
               default:   hit = 1'b0;
            endcase
         end

         always_comb begin
            case (size_i)
               SIZE_BYTE: lane_byte = data_i[BYTE_W-1:0];
               SIZE_HALF: lane_byte = data_i[HSRC +: BYTE_W];
               default:   lane_byte = data_i[WSRC +: BYTE_W];
            endcase
         end

         assign be_o[NLANE-1-i]            = hit & ~block_i;
         assign data_o[WSRC +: BYTE_W]     = lane_byte;
      end
   endgenerate

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_lane_pkg::*;
#(
   parameter int NLANE = 4,
   parameter int OFF_W = 2,
   parameter int IMM_W = 16,
   localparam int DATA_W = NLANE * BYTE_W,
   localparam int HALF_W = 2 * BYTE_W
) (
   input  logic               load_i,
   input  logic               lui_i,
   input  lsu_size_e          size_i,
   input  logic               unsigned_i,
   input  logic [OFF_W-1:0]   offset_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [DATA_W-1:0]  rdata_i,
   output logic [DATA_W-1:0]  result_o
);

   logic [BYTE_W-1:0] lane_b [NLANE];
   logic [BYTE_W-1:0] byte_v;
   logic [HALF_W-1:0] half_v;
   logic              fill_b;
   logic              fill_h;

   generate
      for (genvar i = 0; i < NLANE; i++) begin : g_split
         assign lane_b[i] = rdata_i[(NLANE-1-i)*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign byte_v = lane_b[offset_i];
   assign half_v = {lane_b[{offset_i[OFF_W-1:1], 1'b0}],
                    lane_b[{offset_i[OFF_W-1:1], 1'b1}]};
   assign fill_b = ~unsigned_i & byte_v[BYTE_W-1];
   assign fill_h = ~unsigned_i & half_v[HALF_W-1];

   always_comb begin
      result_o = '0;
      if (lui_i) begin
         result_o = {imm_i, {(DATA_W-IMM_W){1'b0}}};
      end else if (load_i) begin
         case (size_i)
            SIZE_BYTE: result_o = {{(DATA_W-BYTE_W){fill_b}}, byte_v};
            SIZE_HALF: result_o = {{(DATA_W-HALF_W){fill_h}}, half_v};
            SIZE_WORD: result_o = rdata_i;
            default:   result_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
   import lsu_lane_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int DISP_W  = 16,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        req_kind,
   input  logic [1:0]        req_size,
   input  logic              req_unsigned,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   output logic              align_err,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data
);

   localparam int NLANE = DATA_W / BYTE_W;
   localparam int OFF_W = $clog2(NLANE);
   localparam int IMM_W = DISP_W;

   generate
      if (DATA_W != 32) begin : g_chk_data
         $error("lsu_lane_unit: DATA_W must be 32");
      end
      if (DISP_W > ADDR_W || DISP_W >= DATA_W) begin : g_chk_disp
         $error("lsu_lane_unit: DISP_W must fit in ADDR_W and be below DATA_W");
      end
      if (ADDR_W <= OFF_W) begin : g_chk_addr
         $error("lsu_lane_unit: ADDR_W too small");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_chk_reg
         $error("lsu_lane_unit: OUT_REG must be 0 or 1");
      end
   endgenerate

   lsu_kind_e         kind_d;
   lsu_size_e         size_d;
   logic              is_mem_d;
   logic [ADDR_W-1:0] addr_d;
   logic [OFF_W-1:0]  off_d;
   logic              misalign_d;
   logic [NLANE-1:0]  be_d;
   logic [DATA_W-1:0] wdata_d;
   logic              we_d;
   logic              re_d;
   logic              err_d;

   assign kind_d   = lsu_kind_e'(req_kind);
   assign size_d   = lsu_size_e'(req_size);
   assign is_mem_d = (kind_d == KIND_LOAD) || (kind_d == KIND_STORE);

   lsu_addr_gen #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W),
      .OFF_W  (OFF_W)
   ) u_addr (
      .base_i      (req_base),
      .disp_i      (req_disp),
      .size_i      (size_d),
      .word_addr_o (addr_d),
      .offset_o    (off_d),
      .misalign_o  (misalign_d)
   );

   lsu_store_lanes #(
      .NLANE (NLANE),
      .OFF_W (OFF_W)
   ) u_lanes (
      .size_i   (size_d),
      .offset_i (off_d),
      .block_i  (misalign_d | ~is_mem_d),
      .data_i   (req_wdata),
      .be_o     (be_d),
      .data_o   (wdata_d)
   );

   assign we_d  = (kind_d == KIND_STORE) && !misalign_d;
   assign re_d  = (kind_d == KIND_LOAD)  && !misalign_d;
   assign err_d = is_mem_d && misalign_d;

   lsu_kind_e         kind_q;
   lsu_size_e         size_q;
   logic              uns_q;
   logic [OFF_W-1:0]  off_q;
   logic [IMM_W-1:0]  imm_q;
   logic [ADDR_W-1:0] addr_q;
   logic [NLANE-1:0]  be_q;
   logic [DATA_W-1:0] wdata_q;
   logic              we_q;
   logic              re_q;
   logic              err_q;

   generate
      if (OUT_REG == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               kind_q  <= KIND_IDLE;
               size_q  <= SIZE_BYTE;
               uns_q   <= 1'b0;
               off_q   <= '0;
               imm_q   <= '0;
               addr_q  <= '0;
               be_q    <= '0;
               wdata_q <= '0;
               we_q    <= 1'b0;
               re_q    <= 1'b0;
               err_q   <= 1'b0;
            end else begin
               kind_q  <= kind_d;
               size_q  <= size_d;
               uns_q   <= req_unsigned;
               off_q   <= off_d;
               imm_q   <= req_disp;
               addr_q  <= addr_d;
               be_q    <= be_d;
               wdata_q <= wdata_d;
               we_q    <= we_d;
               re_q    <= re_d;
               err_q   <= err_d;
            end
         end

         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (req_kind == 2'b00) |=> (!mem_we && !mem_re && !align_err && !ld_valid && mem_be == '0)); // R10
      end else begin : g_comb
         assign kind_q  = kind_d;
         assign size_q  = size_d;
         assign uns_q   = req_unsigned;
         assign off_q   = off_d;
         assign imm_q   = req_disp;
         assign addr_q  = addr_d;
         assign be_q    = be_d;
         assign wdata_q = wdata_d;
         assign we_q    = we_d;
         assign re_q    = re_d;
         assign err_q   = err_d;
      end
   endgenerate

   logic load_ok_q;
   logic lui_q;

   assign load_ok_q = (kind_q == KIND_LOAD) && !err_q;
   assign lui_q     = (kind_q == KIND_LUI);

   lsu_load_extract #(
      .NLANE (NLANE),
      .OFF_W (OFF_W),
      .IMM_W (IMM_W)
   ) u_extract (
      .load_i     (load_ok_q),
      .lui_i      (lui_q),
      .size_i     (size_q),
      .unsigned_i (uns_q),
      .offset_i   (off_q),
      .imm_i      (imm_q),
      .rdata_i    (mem_rdata),
      .result_o   (ld_data)
   );

   assign mem_addr  = addr_q;
   assign mem_be    = be_q;
   assign mem_wdata = wdata_q;
   assign mem_we    = we_q;
   assign mem_re    = re_q;
   assign align_err = err_q;
   assign ld_valid  = load_ok_q || lui_q;

   AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> (mem_be == '0 && !mem_we && !mem_re && !ld_valid)); // R3

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, mem_re, align_err})); // R6

   AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |->
         ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4)); // R4

   AST_BE_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mem_be) == 2) |-> (mem_be == 4'b1100 || mem_be == 4'b0011)); // R4

   AST_BYTE_REPL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $countones(mem_be) == 1) |->
         (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[23:16] == mem_wdata[7:0] &&
          mem_wdata[15:8] == mem_wdata[7:0])); // R5

   AST_LUI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !mem_re) |-> (ld_data[15:0] == 16'h0000 && mem_be == '0)); // R9

   AST_LD_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |-> (ld_data == '0)); // R11

endmodule

// File: tb/lsu_lane_unit_bench.sv
module lsu_lane_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [1:0]  req_size = 2'b00;
   logic        req_unsigned = 1'b0;
   logic [31:0] req_base = '0;
   logic [15:0] req_disp = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_we;
   logic        mem_re;
   logic        align_err;
   logic        ld_valid;
   logic [31:0] ld_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lsu_lane_unit u_lsu_lane_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_kind     (req_kind),
      .req_size     (req_size),
      .req_unsigned (req_unsigned),
      .req_base     (req_base),
      .req_disp     (req_disp),
      .req_wdata    (req_wdata),
      .mem_rdata    (mem_rdata),
      .mem_addr     (mem_addr),
      .mem_be       (mem_be),
      .mem_wdata    (mem_wdata),
      .mem_we       (mem_we),
      .mem_re       (mem_re),
      .align_err    (align_err),
      .ld_valid     (ld_valid),
      .ld_data      (ld_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One request, one idle cycle; outputs checked one cycle after the request.
   task automatic run(input string tag, input logic [1:0] kind, input logic [1:0] size,
                      input logic uns, input logic [31:0] base, input logic [15:0] disp,
                      input logic [31:0] wd, input logic [31:0] rd);
      logic [31:0] ea;
      logic [1:0]  off;
      logic        mis;
      logic        mem;
      logic [3:0]  e_be;
      logic [31:0] e_wd;
      logic [7:0]  b;
      logic [15:0] h;
      logic [31:0] e_ld;
      logic        e_vld;
      ea   = base + {{16{disp[15]}}, disp};
      off  = ea[1:0];
      mis  = (size == 2'b01 && off[0]) || (size == 2'b10 && off != 2'b00) || size == 2'b11;
      mem  = (kind == 2'b01) || (kind == 2'b10);
      e_be = 4'b0000;
      if (mem && !mis)
         e_be = (size == 2'b00) ? (4'b1000 >> off) :
                (size == 2'b01) ? (off[1] ? 4'b0011 : 4'b1100) : 4'b1111;
      e_wd = (size == 2'b00) ? {4{wd[7:0]}} : (size == 2'b01) ? {2{wd[15:0]}} : wd;
      b    = 8'(rd >> (8 * (3 - off)));
      h    = off[1] ? rd[15:0] : rd[31:16];
      e_vld = (kind == 2'b11) || (kind == 2'b01 && !mis);
      e_ld  = '0;
      if (kind == 2'b11) e_ld = {disp, 16'h0000};
      else if (kind == 2'b01 && !mis) begin
         if (size == 2'b00)      e_ld = uns ? {24'h0, b} : {{24{b[7]}}, b};
         else if (size == 2'b01) e_ld = uns ? {16'h0, h} : {{16{h[15]}}, h};
         else                    e_ld = rd;
      end
      @(negedge clk);
      req_kind = kind; req_size = size; req_unsigned = uns;
      req_base = base; req_disp = disp; req_wdata = wd; mem_rdata = rd;
      @(negedge clk);
      req_kind = 2'b00;
      #1;
      if (mem) chk({tag, " R2 mem_addr"}, mem_addr, {ea[31:2], 2'b00});
      chk({tag, " mem_be"}, {28'h0, mem_be}, {28'h0, e_be});
      chk({tag, " R6 mem_we"}, {31'h0, mem_we}, {31'h0, kind == 2'b10 && !mis});
      chk({tag, " R6 mem_re"}, {31'h0, mem_re}, {31'h0, kind == 2'b01 && !mis});
      chk({tag, " R3 align_err"}, {31'h0, align_err}, {31'h0, mem && mis});
      if (kind == 2'b10 && !mis) chk({tag, " R5 mem_wdata"}, mem_wdata, e_wd);
      chk({tag, " ld_valid"}, {31'h0, ld_valid}, {31'h0, e_vld});
      chk({tag, " R11 ld_data"}, ld_data, e_ld);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 mem_we", {31'h0, mem_we}, 32'h0);
      chk("R1 mem_re", {31'h0, mem_re}, 32'h0);
      chk("R1 align_err", {31'h0, align_err}, 32'h0);
      chk("R1 ld_valid", {31'h0, ld_valid}, 32'h0);
      chk("R1 mem_be", {28'h0, mem_be}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ld_data after release", ld_data, 32'h0);
      chk("R1 mem_be after release", {28'h0, mem_be}, 32'h0);
   endtask

   task automatic t_address();
      run("R2 negative disp", 2'b01, 2'b10, 1'b0, 32'h1000_0000, 16'hFFFC, '0, 32'h0BAD_F00D);
      run("R2 positive disp", 2'b01, 2'b00, 1'b1, 32'h0000_2000, 16'h7FFF, '0, 32'h1122_3344);
      run("R2 wrap", 2'b10, 2'b10, 1'b0, 32'hFFFF_FFF8, 16'h0010, 32'hCAFE_0001, '0);
   endtask

   task automatic t_store();
      for (int k = 0; k < 4; k++)
         run("R4 R5 byte store", 2'b10, 2'b00, 1'b0, 32'h0000_4000, 16'(k), 32'h1234_56A5, '0);
      run("R4 R5 half store off0", 2'b10, 2'b01, 1'b0, 32'h0000_4000, 16'h0000, 32'hDEAD_BEEF, '0);
      run("R4 R5 half store off2", 2'b10, 2'b01, 1'b0, 32'h0000_4000, 16'h0002, 32'hDEAD_BEEF, '0);
      run("R4 R5 word store", 2'b10, 2'b10, 1'b0, 32'h0000_4000, 16'h0000, 32'h0102_0304, '0);
   endtask

   task automatic t_load();
      for (int k = 0; k < 4; k++) begin
         run("R7 R8 byte signed", 2'b01, 2'b00, 1'b0, 32'h0000_8000, 16'(k), '0, 32'h8172_F35A);
         run("R7 R8 byte unsigned", 2'b01, 2'b00, 1'b1, 32'h0000_8000, 16'(k), '0, 32'h8172_F35A);
      end
      run("R7 R8 half signed off0", 2'b01, 2'b01, 1'b0, 32'h0000_8000, 16'h0000, '0, 32'h8172_F35A);
      run("R7 R8 half unsigned off0", 2'b01, 2'b01, 1'b1, 32'h0000_8000, 16'h0000, '0, 32'h8172_F35A);
      run("R7 R8 half signed off2", 2'b01, 2'b01, 1'b0, 32'h0000_8000, 16'h0002, '0, 32'h8172_735A);
      run("R7 R8 half unsigned off2", 2'b01, 2'b01, 1'b1, 32'h0000_8000, 16'h0002, '0, 32'h8172_F35A);
      run("R7 word load", 2'b01, 2'b10, 1'b0, 32'h0000_8000, 16'h0000, '0, 32'hF00D_1234);
      run("R8 word unsigned ignored", 2'b01, 2'b10, 1'b1, 32'h0000_8000, 16'h0000, '0, 32'h8000_0001);
      // Fixed expected values for one signed and one unsigned narrow load.
      @(negedge clk);
      req_kind = 2'b01; req_size = 2'b00; req_unsigned = 1'b0;
      req_base = 32'h0000_0100; req_disp = 16'h0002;
      @(negedge clk);
      req_kind = 2'b00; mem_rdata = 32'h0011_9900;
      #1 chk("R7 R8 byte offset 2 fixed", ld_data, 32'hFFFF_FF99);
      @(negedge clk);
      req_kind = 2'b01; req_size = 2'b01; req_unsigned = 1'b1; req_disp = 16'h0000;
      @(negedge clk);
      req_kind = 2'b00; mem_rdata = 32'hABCD_0000;
      #1 chk("R7 R8 half offset 0 fixed", ld_data, 32'h0000_ABCD);
   endtask

   task automatic t_misalign();
      run("R3 half off1 store", 2'b10, 2'b01, 1'b0, 32'h0000_0000, 16'h0001, 32'hFFFF_FFFF, '0);
      run("R3 half off3 load", 2'b01, 2'b01, 1'b0, 32'h0000_0000, 16'h0003, '0, 32'hFFFF_FFFF);
      for (int k = 1; k < 4; k++)
         run("R3 word misaligned", 2'b10, 2'b10, 1'b0, 32'h0000_0010, 16'(k), 32'h5555_AAAA, '0);
      run("R3 reserved size load", 2'b01, 2'b11, 1'b0, 32'h0000_0020, 16'h0000, '0, 32'h1234_5678);
      run("R3 reserved size store", 2'b10, 2'b11, 1'b0, 32'h0000_0020, 16'h0000, 32'h1, '0);
   endtask

   task automatic t_lui();
      run("R9 upper imm", 2'b11, 2'b10, 1'b0, 32'h1234_5673, 16'hABCD, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run("R9 upper imm neg", 2'b11, 2'b01, 1'b1, 32'h0000_0001, 16'h8001, '0, 32'h0000_FFFF);
   endtask

   task automatic t_idle();
      run("R10 idle", 2'b00, 2'b10, 1'b0, 32'h0000_1000, 16'h0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run("R11 store then no result", 2'b10, 2'b00, 1'b0, 32'h0, 16'h0, 32'h77, 32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_address();
      t_store();
      t_load();
      t_misalign();
      t_lui();
      t_idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule